// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration and Cascadable Busy

This block is a word-organised memory that two independent requesters, called left and right, can reach at the same time. Each side has its own address, data, chip select, write strobe and output enable. Both sides may read the same word in the same cycle with no penalty. When both sides reach one word and at least one of them writes, an arbiter picks a winner. The loser sees its busy flag raised for that cycle and its write is dropped.

A role input chooses how busy is produced. In master role the local arbiter drives the busy outputs. In slave role the busy outputs stay low and the busy inputs decide which writes are blocked. Several instances can therefore sit side by side to form a wider word: one master makes the decision and every slave obeys it. The model runs on a single clock and takes one request per side per cycle. The address width is a parameter: 14 bits gives the full 16K array, and the default is narrower to keep elaboration light.

Top module: `dpr_busy_ram`

## Requirements
- R1: After reset both read data outputs are 0 with output enable high, and both busy outputs are 0 while no side is selected.
- R2: A read (select 1, write 0) returns the addressed word on that side's read data one cycle later. While that side's output enable is 0 the read data output is 0. The captured word reappears when output enable returns to 1.
- R3: Both sides may read any addresses, including the same one, in the same cycle. Each side gets its word and no busy is raised.
- R4: A collision is both sides selected on equal addresses with at least one writing. In master role (role input 1), busy is raised on exactly one side during a collision and on neither side otherwise.
- R5: In master role, when both sides start a colliding request in the same cycle, left wins: right busy is 1 and only the left write lands.
- R6: In master role, a side that kept the same selected address from the previous cycle wins against a side that has just arrived. While the collision persists unchanged, the winner stays the same.
- R7: A side whose busy is in effect has its write suppressed, but its read still returns data.
- R8: In slave role (role input 0), both busy outputs are 0 and the local arbitration result is ignored. A 1 on a side's busy input blocks that side's write.
- R9: If both sides write one address in the same cycle and neither is blocked (slave role, busy inputs 0), the left data is kept.
- R10: A read in the same cycle as a write to the same address returns the word held before that write.
- R11: In master role the two busy outputs are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_sel | input | 1 | Role: 1 master (drives busy), 0 slave (obeys busy inputs) |
| l_cs | input | 1 | Left select |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | AW | Left address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data, 0 while output enable is low |
| l_busy_o | output | 1 | Left busy from the local arbiter (master role) |
| l_busy_i | input | 1 | Left busy from an external master (slave role) |
| r_cs | input | 1 | Right select |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | AW | Right address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data, 0 while output enable is low |
| r_busy_o | output | 1 | Right busy from the local arbiter (master role) |
| r_busy_i | input | 1 | Right busy from an external master (slave role) |

## Verification
The bench targets the winner choice. It covers an exact tie, a newcomer meeting a side that was already holding the word, and a collision that lasts several cycles. An arbiter that ignored history would flip the winner mid-collision and corrupt the held side's access. It also reads a word in the same cycle another side overwrites it, where a write-first array would return the new value too early. In slave role it raises the local collision while holding the busy inputs low, so any leak of the local decision shows up on the busy outputs or as a lost write. It also checks that a busy read still returns data and that output enable only gates the output and does not destroy the captured word.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned SIDES  = 2;
  localparam int unsigned SIDE_L = 0;
  localparam int unsigned SIDE_R = 1;

  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;
endpackage

// File: rtl/dpr_rst_sync.sv
module dpr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter #(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_cs,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic          r_cs,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  output logic          lose_l,
  output logic          lose_r
);
  // request history: one entry per side
  logic          hist_l_cs_q, hist_l_cs_d;
  logic          hist_r_cs_q, hist_r_cs_d;
  logic [AW-1:0] hist_l_addr_q, hist_l_addr_d;
  logic [AW-1:0] hist_r_addr_q, hist_r_addr_d;
  logic          hist_l_en, hist_r_en;
  logic          col_q, col_d;
  logic          win_r_q, win_r_d;

  logic          collide;
  logic          held_l, held_r;
  logic          win_r;

  always_comb begin
    collide = l_cs && r_cs && (l_addr == r_addr) && (l_we || r_we);
    held_l  = l_cs && hist_l_cs_q && (l_addr == hist_l_addr_q);
    held_r  = r_cs && hist_r_cs_q && (r_addr == hist_r_addr_q);

    win_r = 1'b0;
    if (collide) begin
      if (held_l && held_r && col_q) begin
        win_r = win_r_q;          // ongoing collision keeps its owner
      end else if (held_r && !held_l) begin
        win_r = 1'b1;             // earlier requester wins
      end else begin
        win_r = 1'b0;             // tie or left earlier: left wins
      end
    end

    lose_l = collide && win_r;
    lose_r = collide && !win_r;
  end

  // next-state
  always_comb begin
    hist_l_cs_d   = l_cs;
    hist_r_cs_d   = r_cs;
    hist_l_en     = l_cs;
    hist_r_en     = r_cs;
    hist_l_addr_d = l_addr;
    hist_r_addr_d = r_addr;
    col_d         = collide;
    win_r_d       = win_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_l_cs_q <= 1'b0;
      hist_r_cs_q <= 1'b0;
      col_q       <= 1'b0;
      win_r_q     <= 1'b0;
    end else begin
      hist_l_cs_q <= hist_l_cs_d;
      hist_r_cs_q <= hist_r_cs_d;
      col_q       <= col_d;
      win_r_q     <= win_r_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_l_addr_q <= '0;
      hist_r_addr_q <= '0;
    end else begin
      if (hist_l_en) hist_l_addr_q <= hist_l_addr_d;
      if (hist_r_en) hist_r_addr_q <= hist_r_addr_d;
    end
  end
endmodule

// File: rtl/dpr_port_gate.sv
module dpr_port_gate #(
  parameter int unsigned DW = 8
) (
  input  logic          ms_sel,
  input  logic          cs,
  input  logic          we,
  input  logic          oe,
  input  logic          lose,
  input  logic          busy_ext,
  input  logic [DW-1:0] rd_word,
  output logic          busy_o,
  output logic          wr_en,
  output logic          rd_en,
  output logic [DW-1:0] rdata
);
  import dpr_pkg::*;

  role_e role;
  logic  busy_eff;

  always_comb begin
    role     = role_e'(ms_sel);
    busy_eff = (role == ROLE_MASTER) ? lose : busy_ext;
    busy_o   = (role == ROLE_MASTER) && lose;
    wr_en    = cs && we && !busy_eff;
    rd_en    = cs && !we;
    rdata    = oe ? rd_word : '0;
  end
endmodule

// File: rtl/dpr_mem_array.sv
module dpr_mem_array #(
  parameter int unsigned AW    = 11,
  parameter int unsigned DW    = 8,
  parameter int unsigned SIDES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SIDES-1:0]          wr_en,
  input  logic [SIDES-1:0]          rd_en,
  input  logic [SIDES-1:0][AW-1:0]  addr,
  input  logic [SIDES-1:0][DW-1:0]  wdata,
  output logic [SIDES-1:0][DW-1:0]  rd_word
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // higher index first, so side 0 (left) lands last and keeps priority
  always_ff @(posedge clk) begin
    for (int s = SIDES - 1; s >= 0; s--) begin
      if (wr_en[s]) mem[addr[s]] <= wdata[s];
    end
  end

  for (genvar g = 0; g < SIDES; g++) begin : g_rd
    logic [DW-1:0] rd_q, rd_d;

    always_comb begin
      rd_d = mem[addr[g]];     // value before this edge's write
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q <= '0;
      end else if (rd_en[g]) begin
        rd_q <= rd_d;
      end
    end

    assign rd_word[g] = rd_q;
  end
endmodule

// File: rtl/dpr_busy_ram.sv
module dpr_busy_ram #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_sel,
  input  logic          l_cs,
  input  logic          l_we,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_busy_o,
  input  logic          l_busy_i,
  input  logic          r_cs,
  input  logic          r_we,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_busy_o,
  input  logic          r_busy_i
);
  import dpr_pkg::*;

  logic rst_n_int;

  logic [SIDES-1:0]         cs_v, we_v, oe_v, lose_v, bext_v, busy_v;
  logic [SIDES-1:0]         wr_en_v, rd_en_v;
  logic [SIDES-1:0][AW-1:0] addr_v;
  logic [SIDES-1:0][DW-1:0] wdata_v, rd_word_v, rdata_v;

  dpr_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  always_comb begin
    cs_v[SIDE_L]    = l_cs;     cs_v[SIDE_R]    = r_cs;
    we_v[SIDE_L]    = l_we;     we_v[SIDE_R]    = r_we;
    oe_v[SIDE_L]    = l_oe;     oe_v[SIDE_R]    = r_oe;
    addr_v[SIDE_L]  = l_addr;   addr_v[SIDE_R]  = r_addr;
    wdata_v[SIDE_L] = l_wdata;  wdata_v[SIDE_R] = r_wdata;
    bext_v[SIDE_L]  = l_busy_i; bext_v[SIDE_R]  = r_busy_i;
  end

  dpr_arbiter #(.AW(AW)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .l_cs   (l_cs),
    .l_we   (l_we),
    .l_addr (l_addr),
    .r_cs   (r_cs),
    .r_we   (r_we),
    .r_addr (r_addr),
    .lose_l (lose_v[SIDE_L]),
    .lose_r (lose_v[SIDE_R])
  );

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dpr_port_gate #(.DW(DW)) u_gate (
      .ms_sel   (ms_sel),
      .cs       (cs_v[g]),
      .we       (we_v[g]),
      .oe       (oe_v[g]),
      .lose     (lose_v[g]),
      .busy_ext (bext_v[g]),
      .rd_word  (rd_word_v[g]),
      .busy_o   (busy_v[g]),
      .wr_en    (wr_en_v[g]),
      .rd_en    (rd_en_v[g]),
      .rdata    (rdata_v[g])
    );
  end

  dpr_mem_array #(.AW(AW), .DW(DW), .SIDES(SIDES)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en_v),
    .rd_en   (rd_en_v),
    .addr    (addr_v),
    .wdata   (wdata_v),
    .rd_word (rd_word_v)
  );

  assign l_rdata  = rdata_v[SIDE_L];
  assign r_rdata  = rdata_v[SIDE_R];
  assign l_busy_o = busy_v[SIDE_L];
  assign r_busy_o = busy_v[SIDE_R];
endmodule

// File: rtl/dpr_busy_ram_chk.sv
module dpr_busy_ram_chk #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ms_sel,
  input logic          l_cs,
  input logic          l_we,
  input logic          l_oe,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_rdata,
  input logic          l_busy_o,
  input logic          r_cs,
  input logic          r_we,
  input logic          r_oe,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_rdata,
  input logic          r_busy_o
);
  logic       col;
  logic [2:0] settle_q;

  assign col = l_cs && r_cs && (l_addr == r_addr) && (l_we || r_we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
    end else if (settle_q != 3'd4) begin
      settle_q <= settle_q + 3'd1;
    end
  end

  // R11
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ms_sel |-> !(l_busy_o && r_busy_o));

  // R4
  no_col_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_sel && !col) |-> (!l_busy_o && !r_busy_o));

  // R4
  col_one_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_sel && col) |-> ($countones({l_busy_o, r_busy_o}) == 1));

  // R8
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_sel |-> (!l_busy_o && !r_busy_o));

  // R2
  l_oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_oe |-> (l_rdata == '0));

  // R2
  r_oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_oe |-> (r_rdata == '0));

  // R6
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q == 3'd4 && ms_sel && col && $past(ms_sel && col) &&
     $stable(l_addr) && $stable(r_addr))
    |-> $stable({l_busy_o, r_busy_o}));
endmodule

bind dpr_busy_ram dpr_busy_ram_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_dpr_busy_ram.sv
module test_dpr_busy_ram;
  localparam int unsigned AW    = 11;
  localparam int unsigned DW    = 8;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          ms_sel;
  logic          l_cs, l_we, l_oe, l_busy_i;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_wdata, l_rdata;
  logic          l_busy_o;
  logic          r_cs, r_we, r_oe, r_busy_i;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_wdata, r_rdata;
  logic          r_busy_o;

  dpr_busy_ram #(.AW(AW), .DW(DW)) i_dpr_busy_ram (
    .clk(clk), .rst_n(rst_n), .ms_sel(ms_sel),
    .l_cs(l_cs), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_busy_o(l_busy_o), .l_busy_i(l_busy_i),
    .r_cs(r_cs), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_busy_o(r_busy_o), .r_busy_i(r_busy_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  int unsigned cyc      = 0;
  logic [DW-1:0] model [DEPTH];

  typedef struct {
    int unsigned   due;
    bit            side_r;
    logic [DW-1:0] val;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: compares read data against queued expectations
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_t e;
      logic [DW-1:0] want;
      e = sb_q.pop_front();
      if (!e.side_r) begin
        want = l_oe ? e.val : '0;
        chk(l_rdata === want, e.tag, int'(l_rdata), int'(want));
      end else begin
        want = r_oe ? e.val : '0;
        chk(r_rdata === want, e.tag, int'(r_rdata), int'(want));
      end
    end
  end

  // driver: one cycle of requests, expected busy given per requirements
  task automatic step(
    input bit lcs, input bit lwe, input int la, input int ld,
    input bit rcs, input bit rwe, input int ra, input int rd,
    input bit elb, input bit erb, input string tag);
    bit lbe, rbe;
    l_cs = lcs; l_we = lwe; l_addr = AW'(la); l_wdata = DW'(ld);
    r_cs = rcs; r_we = rwe; r_addr = AW'(ra); r_wdata = DW'(rd);
    #1;
    chk(l_busy_o === elb, {tag, " left busy"},  int'(l_busy_o), int'(elb));
    chk(r_busy_o === erb, {tag, " right busy"}, int'(r_busy_o), int'(erb));
    if (lcs && !lwe) sb_q.push_back('{cyc + 1, 1'b0, model[AW'(la)], {tag, " left read"}});
    if (rcs && !rwe) sb_q.push_back('{cyc + 1, 1'b1, model[AW'(ra)], {tag, " right read"}});
    lbe = ms_sel ? elb : l_busy_i;
    rbe = ms_sel ? erb : r_busy_i;
    if (rcs && rwe && !rbe) model[AW'(ra)] = DW'(rd);
    if (lcs && lwe && !lbe) model[AW'(la)] = DW'(ld);   // R9 left last
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    rst_n = 1'b0; ms_sel = 1'b1;
    l_cs = 0; l_we = 0; l_oe = 1; l_addr = '0; l_wdata = '0; l_busy_i = 0;
    r_cs = 0; r_we = 0; r_oe = 1; r_addr = '0; r_wdata = '0; r_busy_i = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    // R1 reset state
    chk(l_rdata === '0, "R1 left rdata", int'(l_rdata), 0);
    chk(r_rdata === '0, "R1 right rdata", int'(r_rdata), 0);
    chk(l_busy_o === 1'b0 && r_busy_o === 1'b0, "R1 busy", int'({l_busy_o, r_busy_o}), 0);

    // R4 distinct addresses, both writing: no busy
    step(1, 1, 5, 'hA5, 1, 1, 9, 'h3C, 0, 0, "R4 distinct writes");
    // R2 crossed reads
    step(1, 0, 9, 0, 1, 0, 5, 0, 0, 0, "R2 crossed reads");
    // R3 same-address reads
    step(1, 0, 5, 0, 1, 0, 5, 0, 0, 0, "R3 shared read");
    idle();
    // R5 tie
    step(1, 1, 7, 'h11, 1, 1, 7, 'h22, 0, 1, "R5 tie");
    step(1, 0, 7, 0, 0, 0, 0, 0, 0, 0, "R5 readback");
    idle();
    // R6 earlier requester wins and holds
    step(1, 1, 20, 'h99, 0, 0, 0, 0, 0, 0, "R6 setup");
    idle();
    step(0, 0, 0, 0, 1, 0, 20, 0, 0, 0, "R6 right arrives");
    step(1, 1, 20, 'h55, 1, 0, 20, 0, 1, 0, "R6 newcomer left loses");
    step(1, 1, 20, 'h56, 1, 0, 20, 0, 1, 0, "R6 owner kept");
    idle();
    step(1, 0, 20, 0, 0, 0, 0, 0, 0, 0, "R6 write dropped");
    idle();
    // R7 / R10 busy read returns old word
    step(1, 1, 30, 'h77, 0, 0, 0, 0, 0, 0, "R10 setup");
    step(1, 1, 30, 'h78, 1, 0, 30, 0, 0, 1, "R7 R10 busy read old");
    step(0, 0, 0, 0, 1, 0, 30, 0, 0, 0, "R10 new word");
    idle();
    // R2 output enable gating
    l_oe = 0;
    step(1, 0, 5, 0, 0, 0, 0, 0, 0, 0, "R2 oe low");
    idle();
    l_oe = 1;
    #1;
    chk(l_rdata === 8'hA5, "R2 oe restore", int'(l_rdata), 'hA5);
    @(posedge clk); #2;
    // R8 / R9 slave role
    ms_sel = 0;
    idle();
    step(1, 1, 40, 'hAA, 1, 1, 40, 'hBB, 0, 0, "R8 R9 slave dual write");
    step(1, 0, 40, 0, 0, 0, 0, 0, 0, 0, "R9 left kept");
    r_busy_i = 1;
    step(0, 0, 0, 0, 1, 1, 9, 'hEE, 0, 0, "R8 busy in blocks");
    r_busy_i = 0;
    step(0, 0, 0, 0, 1, 0, 9, 0, 0, 0, "R8 write blocked");
    l_busy_i = 1;
    step(1, 0, 5, 0, 0, 0, 0, 0, 0, 0, "R7 slave busy read");
    l_busy_i = 0;
    ms_sel = 1;
    idle();
    idle();
    chk(sb_q.size() == 0, "R2 queue drained", sb_q.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule